// File: doc/BRIEF.md
# Asynchronous Schedule Fetch Controller

This block decides when the asynchronous-list DMA engine of a USB host controller may read memory, and which read comes next. It walks the circular list of queue heads. For each queue head it reads the head, then the transfer descriptor the head points at, and then any outbound payload the descriptor describes. A separate parser decodes the returned structures and hands back only a few fields: the head-of-list flag, two pointers, the OUT flag and the payload length. The port executor reports each finished USB transaction with a single-cycle pulse.

Reads go out on a valid/ready request channel. A request, once raised, keeps its kind, address and length stable until `req_ready_i` is seen high at a clock edge. The engine never withdraws a request. Stalling `req_ready_i` stalls the whole walk. Responses are plain one-cycle strobes. They are consumed only while the controller waits for the structure it asked for, and are ignored at any other time. Two transaction slots let the structures for the next transaction be fetched while the current one runs on the bus. Outbound payloads are cut into requests no larger than a programmable chunk, and no chunk crosses a chunk-aligned boundary.

Top module: `asf_fetch_ctrl`

## Requirements
- R1: A request is raised only in a cycle after one in which `run_i`, `sched_en_i` and `bm_en_i` were all high and the engine was awake. While any one of these is low, no new request appears.
- R2: Reading a queue head that has the head flag set while `recl_i` is low puts the engine to sleep, and no further reads are issued. A `wake_i` pulse, or a low `sched_en_i` or `run_i`, ends the sleep. If `recl_i` is high, the same queue head is followed normally.
- R3: The first queue head after reset, or after `sched_en_i` or `run_i` has been low, is read at `list_addr_i`. Each later queue head is read at the link pointer (`rsp_ptr0_i`) of the previous queue head. After a sleep, the engine re-reads the queue head that caused it.
- R4: Exactly two slots exist. A slot becomes occupied when a descriptor response is consumed, and is freed by a `done_i` pulse. When a free slot is the only thing missing, the queue-head request rises on the second clock edge that samples the pulse, counting the edge that samples it as the first.
- R5: While both slots are occupied, no queue-head or descriptor read is raised. Payload reads of the transaction whose descriptor filled the second slot are still issued.
- R6: One transaction is fetched strictly in order: queue head, descriptor, then all of its payload reads. No read of the next transaction is raised before all of them have been accepted.
- R7: With `prefetch_en_i` low, a queue-head read is raised only when no slot is occupied.
- R8: Kind codes are 0 for queue head, 1 for descriptor and 2 for payload. A queue-head read is 17 dwords and a descriptor read is 13 dwords. The queue head's address comes from R3, and the descriptor's address is the queue head's `rsp_ptr1_i`.
- R9: Payload reads are made only when the descriptor reports OUT with a nonzero length. The total is min(length, 129) dwords, starting at `rsp_ptr0_i` with bits 1:0 cleared. With chunk size M = 16 << `max_len_sel_i` dwords, each request covers min(remaining, M − (dword index mod M)) dwords, and the address advances by 4 bytes per dword.
- R10: While `req_valid_o` is high and `req_ready_i` low, `req_valid_o`, `req_kind_o`, `req_addr_o` and `req_len_o` hold their values on the next cycle.
- R11: A `done_i` pulse while no slot is occupied has no effect on the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Controller running (not halted) |
| sched_en_i | input | 1 | Asynchronous schedule status active |
| bm_en_i | input | 1 | Bus-master access enabled |
| prefetch_en_i | input | 1 | Allow fetch of a second transaction |
| recl_i | input | 1 | Reclamation status |
| wake_i | input | 1 | Pulse that ends the sleep state |
| list_addr_i | input | 32 | Current asynchronous list address |
| max_len_sel_i | input | 2 | Payload chunk select, M = 16 << value dwords |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_kind_o | output | 2 | 0 queue head, 1 descriptor, 2 payload |
| req_addr_o | output | 32 | Byte address of the read |
| req_len_o | output | 8 | Length in dwords |
| rsp_valid_i | input | 1 | Parsed structure available |
| rsp_head_i | input | 1 | Queue head's head-of-list flag |
| rsp_ptr0_i | input | 32 | Queue head: link pointer; descriptor: payload pointer |
| rsp_ptr1_i | input | 32 | Queue head: descriptor pointer |
| rsp_out_i | input | 1 | Descriptor is an OUT transfer |
| rsp_len_i | input | 8 | Descriptor payload length in dwords |
| done_i | input | 1 | Port executor finished one transaction |

## Verification
The bound checker watches, on every cycle, the properties that relate the request channel to its own past. These are the stability of a stalled request, the fixed structure lengths, payload chunks staying inside one aligned window, the four-way gate and the sleep state seen on the cycle before a rise, and the slot ceiling on control reads, including the stricter one with prefetch disabled. Only the bench scenarios can show the walk itself. They cover which address each queue head comes from after start, sleep and restart, the order of the three read kinds, the exact two-edge refill latency, payload reads going on while both slots are full, and the exact chunk sequences. A sweep over every chunk select, three window offsets and five lengths, including lengths above the clamp, exercises the chunk sequences.

// File: rtl/asf_pkg.sv
package asf_pkg;
  typedef enum logic [1:0] {
    RK_QH   = 2'd0,
    RK_TD   = 2'd1,
    RK_DATA = 2'd2
  } req_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_Q_ISS,
    S_Q_RSP,
    S_T_GO,
    S_T_ISS,
    S_T_RSP,
    S_D_GO,
    S_D_ISS
  } fsm_e;

  localparam int QH_DW = 17;
  localparam int TD_DW = 13;
endpackage

// File: rtl/asf_gate.sv
// Combines the three enable levels with the self-entered sleep state.
module asf_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sched_i,
  input  logic bm_i,
  input  logic wake_i,
  input  logic sleep_set_i,
  output logic go_o,
  output logic asleep_o,
  output logic restart_o
);
  logic asleep_q;

  assign restart_o = !run_i || !sched_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
    end else if (restart_o || wake_i) begin
      asleep_q <= 1'b0;   // clearing wins over a same-cycle entry
    end else if (sleep_set_i) begin
      asleep_q <= 1'b1;
    end
  end

  assign asleep_o = asleep_q;
  assign go_o     = run_i && sched_i && bm_i && !asleep_q;
endmodule

// File: rtl/asf_slots.sv
// Counts transactions whose control structures have been fetched and
// which the port executor has not yet retired.
module asf_slots #(
  parameter int NUM_SLOTS = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec = done_i && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({fill_i, dec})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/asf_split.sv
// Size of the next payload chunk: the remaining length, cut at the next
// boundary of a window of BASE_DW << sel dwords.
module asf_split #(
  parameter int LEN_W   = 8,
  parameter int SEL_W   = 2,
  parameter int BASE_DW = 16
) (
  input  logic [LEN_W:0]   idx_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LEN_W-1:0] chunk_o
);
  localparam int MW = LEN_W + 1;

  logic [MW-1:0] win, off, room, rem_w;

  always_comb begin
    win     = MW'(BASE_DW) << sel_i;
    off     = idx_i & (win - MW'(1));
    room    = win - off;
    rem_w   = {1'b0, rem_i};
    chunk_o = (rem_w < room) ? rem_i : room[LEN_W-1:0];
  end
endmodule

// File: rtl/asf_fetch_ctrl.sv
module asf_fetch_ctrl
  import asf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int NUM_SLOTS   = 2,
  parameter int BASE_DW     = 16,
  parameter int SEL_W       = 2,
  parameter int MAX_DATA_DW = 129
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              sched_en_i,
  input  logic              bm_en_i,
  input  logic              prefetch_en_i,
  input  logic              recl_i,
  input  logic              wake_i,
  input  logic [ADDR_W-1:0] list_addr_i,
  input  logic [SEL_W-1:0]  max_len_sel_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [1:0]        req_kind_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_head_i,
  input  logic [ADDR_W-1:0] rsp_ptr0_i,
  input  logic [ADDR_W-1:0] rsp_ptr1_i,
  input  logic              rsp_out_i,
  input  logic [LEN_W-1:0]  rsp_len_i,
  input  logic              done_i
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam int PAD_W = ADDR_W - LEN_W - 2;

  fsm_e              state_q;
  logic              go, asleep, restart, sleep_set, fill, finish;
  logic              slot_room, can_start, accept, has_data;
  logic [CNT_W-1:0]  rdy_cnt;
  logic [ADDR_W-1:0] cur_q, nxt_q, td_q, dat_q, qh_q, qh_addr;
  logic              addr_ok_q;
  logic [LEN_W-1:0]  rem_q, chunk, chunk_q, clamp_len;

  logic              valid_q;
  req_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;

  asf_gate gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_i),
    .sched_i    (sched_en_i),
    .bm_i       (bm_en_i),
    .wake_i     (wake_i),
    .sleep_set_i(sleep_set),
    .go_o       (go),
    .asleep_o   (asleep),
    .restart_o  (restart)
  );

  asf_slots #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) slots_i (
    .clk   (clk),
    .rst_n (rst_n),
    .fill_i(fill),
    .done_i(done_i),
    .cnt_o (rdy_cnt)
  );

  asf_split #(.LEN_W(LEN_W), .SEL_W(SEL_W), .BASE_DW(BASE_DW)) split_i (
    .idx_i  (dat_q[LEN_W+2:2]),
    .rem_i  (rem_q),
    .sel_i  (max_len_sel_i),
    .chunk_o(chunk)
  );

  // Slot availability and start condition use only registered state, so a
  // completion pulse takes effect one cycle after it is sampled.
  assign slot_room = (rdy_cnt < CNT_W'(NUM_SLOTS)) && (prefetch_en_i || rdy_cnt == '0);
  assign can_start = (state_q == S_IDLE) && go && slot_room;
  assign accept    = valid_q && req_ready_i;
  assign qh_addr   = addr_ok_q ? cur_q : list_addr_i;
  assign has_data  = rsp_out_i && (rsp_len_i != '0);
  assign clamp_len = (rsp_len_i > LEN_W'(MAX_DATA_DW)) ? LEN_W'(MAX_DATA_DW) : rsp_len_i;
  assign sleep_set = (state_q == S_Q_RSP) && rsp_valid_i && rsp_head_i && !recl_i;
  assign fill      = (state_q == S_T_RSP) && rsp_valid_i;
  assign finish    = (fill && !has_data) ||
                     ((state_q == S_D_ISS) && accept && (rem_q == chunk_q));

  // Walk through one transaction.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_q     <= '0;
      nxt_q     <= '0;
      td_q      <= '0;
      dat_q     <= '0;
      qh_q      <= '0;
      rem_q     <= '0;
      chunk_q   <= '0;
      addr_ok_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (can_start) begin
          qh_q    <= qh_addr;
          state_q <= S_Q_ISS;
        end
        S_Q_ISS: if (accept) state_q <= S_Q_RSP;
        S_Q_RSP: if (rsp_valid_i) begin
          if (sleep_set) begin
            cur_q     <= qh_q;      // resume at this queue head after wake
            addr_ok_q <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            nxt_q   <= rsp_ptr0_i;
            td_q    <= rsp_ptr1_i;
            state_q <= S_T_GO;
          end
        end
        S_T_GO:  if (go) state_q <= S_T_ISS;
        S_T_ISS: if (accept) state_q <= S_T_RSP;
        S_T_RSP: if (rsp_valid_i) begin
          if (has_data) begin
            dat_q   <= {rsp_ptr0_i[ADDR_W-1:2], 2'b00};
            rem_q   <= clamp_len;
            state_q <= S_D_GO;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_D_GO: if (go) begin
          chunk_q <= chunk;
          state_q <= S_D_ISS;
        end
        S_D_ISS: if (accept) begin
          rem_q   <= rem_q - chunk_q;
          dat_q   <= dat_q + {{PAD_W{1'b0}}, chunk_q, 2'b00};
          state_q <= (rem_q == chunk_q) ? S_IDLE : S_D_GO;
        end
        default: state_q <= S_IDLE;
      endcase

      if (finish) begin
        cur_q     <= nxt_q;
        addr_ok_q <= 1'b1;
      end
      if (restart) addr_ok_q <= 1'b0;
    end
  end

  // Request register: raised from a GO point, dropped on acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= RK_QH;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      if (accept) valid_q <= 1'b0;
      if (can_start) begin
        valid_q <= 1'b1;
        kind_q  <= RK_QH;
        addr_q  <= qh_addr;
        len_q   <= LEN_W'(QH_DW);
      end else if ((state_q == S_T_GO) && go) begin
        valid_q <= 1'b1;
        kind_q  <= RK_TD;
        addr_q  <= td_q;
        len_q   <= LEN_W'(TD_DW);
      end else if ((state_q == S_D_GO) && go) begin
        valid_q <= 1'b1;
        kind_q  <= RK_DATA;
        addr_q  <= dat_q;
        len_q   <= chunk;
      end
    end
  end

  assign req_valid_o = valid_q;
  assign req_kind_o  = kind_q;
  assign req_addr_o  = addr_q;
  assign req_len_o   = len_q;
endmodule

// File: rtl/asf_fetch_ctrl_chk.sv
module asf_fetch_ctrl_chk #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 8,
  parameter int NUM_SLOTS   = 2,
  parameter int BASE_DW     = 16,
  parameter int SEL_W       = 2,
  parameter int MAX_DATA_DW = 129,
  parameter int CNT_W       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic              sched_en_i,
  input logic              bm_en_i,
  input logic              prefetch_en_i,
  input logic [SEL_W-1:0]  max_len_sel_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [1:0]        req_kind_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [LEN_W-1:0]  req_len_o,
  input logic [CNT_W-1:0]  rdy_cnt,
  input logic              asleep
);
  int win_dw, off_dw;
  always_comb begin
    win_dw = BASE_DW << max_len_sel_i;
    off_dw = int'(req_addr_o[ADDR_W-1:2]) % win_dw;
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_kind_o) &&
      $stable(req_addr_o) && $stable(req_len_o));

  assert_gate_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> $past(run_i && sched_en_i && bm_en_i));

  assert_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) |-> !$past(asleep));

  assert_qh_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_kind_o == 2'd0 |-> int'(req_len_o) == 17);

  assert_td_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_kind_o == 2'd1 |-> int'(req_len_o) == 13);

  assert_kind_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_kind_o != 2'd3);

  assert_chunk_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_kind_o == 2'd2 |-> req_len_o != '0 &&
      int'(req_len_o) <= MAX_DATA_DW && off_dw + int'(req_len_o) <= win_dw &&
      req_addr_o[1:0] == 2'b00);

  assert_slot_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rdy_cnt) <= NUM_SLOTS);

  assert_ctrl_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) && req_kind_o != 2'd2 |-> int'($past(rdy_cnt)) < NUM_SLOTS);

  assert_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid_o) && req_kind_o == 2'd0 && !$past(prefetch_en_i) |->
      $past(rdy_cnt) == '0);
endmodule

bind asf_fetch_ctrl asf_fetch_ctrl_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_SLOTS(NUM_SLOTS), .BASE_DW(BASE_DW),
  .SEL_W(SEL_W), .MAX_DATA_DW(MAX_DATA_DW), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_i        (run_i),
  .sched_en_i   (sched_en_i),
  .bm_en_i      (bm_en_i),
  .prefetch_en_i(prefetch_en_i),
  .max_len_sel_i(max_len_sel_i),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_kind_o   (req_kind_o),
  .req_addr_o   (req_addr_o),
  .req_len_o    (req_len_o),
  .rdy_cnt      (rdy_cnt),
  .asleep       (asleep)
);

// File: tb/asf_fetch_ctrl_tb_top.sv
module asf_fetch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_i, sched_en_i, bm_en_i, prefetch_en_i, recl_i, wake_i;
  logic [31:0] list_addr_i;
  logic [1:0]  max_len_sel_i;
  logic        req_valid_o, req_ready_i;
  logic [1:0]  req_kind_o;
  logic [31:0] req_addr_o;
  logic [7:0]  req_len_o;
  logic        rsp_valid_i, rsp_head_i, rsp_out_i, done_i;
  logic [31:0] rsp_ptr0_i, rsp_ptr1_i;
  logic [7:0]  rsp_len_i;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  asf_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .sched_en_i(sched_en_i),
    .bm_en_i(bm_en_i), .prefetch_en_i(prefetch_en_i), .recl_i(recl_i),
    .wake_i(wake_i), .list_addr_i(list_addr_i), .max_len_sel_i(max_len_sel_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_kind_o(req_kind_o),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .rsp_valid_i(rsp_valid_i),
    .rsp_head_i(rsp_head_i), .rsp_ptr0_i(rsp_ptr0_i), .rsp_ptr1_i(rsp_ptr1_i),
    .rsp_out_i(rsp_out_i), .rsp_len_i(rsp_len_i), .done_i(done_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_req(input int kind, input longint addr, input int len,
                            input string tag, input int hold);
    int w = 0;
    while (!req_valid_o && w < 80) begin
      tick();
      w++;
    end
    if (!req_valid_o) begin
      chk(1'b0, tag, "request missing", 0, 1);
    end else begin
      bit same = 1'b1;
      logic [1:0]  k0 = req_kind_o;
      logic [31:0] a0 = req_addr_o;
      logic [7:0]  l0 = req_len_o;
      chk(req_kind_o == 2'(kind), tag, "kind", req_kind_o, kind);
      chk(req_addr_o == 32'(addr), tag, "address", req_addr_o, addr);
      chk(req_len_o == 8'(len), tag, "length", req_len_o, len);
      if (hold > 0) begin
        req_ready_i = 1'b0;
        for (int i = 0; i < hold; i++) begin
          tick();
          if (!req_valid_o || req_kind_o != k0 || req_addr_o != a0 || req_len_o != l0)
            same = 1'b0;
        end
        chk(same, "R10", "stalled request stable", same, 1);
      end
      req_ready_i = 1'b1;
      tick();
      req_ready_i = 1'b0;
    end
  endtask

  task automatic rsp_qh(input bit head, input logic [31:0] link, input logic [31:0] td);
    rsp_head_i  = head;
    rsp_ptr0_i  = link;
    rsp_ptr1_i  = td;
    rsp_valid_i = 1'b1;
    tick();
    rsp_valid_i = 1'b0;
  endtask

  task automatic rsp_td(input bit out, input logic [31:0] dptr, input int len);
    rsp_out_i   = out;
    rsp_ptr0_i  = dptr;
    rsp_len_i   = 8'(len);
    rsp_valid_i = 1'b1;
    tick();
    rsp_valid_i = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = req_valid_o;
    for (int i = 0; i < n; i++) begin
      tick();
      if (req_valid_o) seen = 1'b1;
    end
    chk(!seen, tag, "request while blocked", seen, 0);
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    tick();
    done_i = 1'b0;
  endtask

  // Expected chunk sequence computed from the window arithmetic of R9.
  task automatic data_seq(input logic [31:0] dptr, input int dlen, input int sel,
                          input string tag);
    int rem = (dlen > 129) ? 129 : dlen;
    longint idx = longint'(dptr >> 2);
    int win = 16 << sel;
    while (rem > 0) begin
      int room = win - int'(idx % win);
      int c = (rem < room) ? rem : room;
      expect_req(2, idx * 4, c, tag, 0);
      rem -= c;
      idx += c;
    end
  endtask

  task automatic do_fetch(input logic [31:0] qh, input logic [31:0] nxt,
                          input logic [31:0] td, input bit out,
                          input logic [31:0] dptr, input int dlen, input string tag);
    expect_req(0, qh, 17, tag, 0);
    rsp_qh(1'b0, nxt, td);
    expect_req(1, td, 13, "R8", 0);
    rsp_td(out, dptr, dlen);
    if (out && dlen > 0) data_seq(dptr, dlen, int'(max_len_sel_i), "R9");
  endtask

  initial begin
    int n;
    logic [31:0] q;
    rst_n = 1'b0; run_i = 1'b0; sched_en_i = 1'b0; bm_en_i = 1'b0;
    prefetch_en_i = 1'b1; recl_i = 1'b0; wake_i = 1'b0;
    list_addr_i = 32'h0000_1000; max_len_sel_i = 2'd0;
    req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_head_i = 1'b0; rsp_out_i = 1'b0;
    rsp_ptr0_i = '0; rsp_ptr1_i = '0; rsp_len_i = '0; done_i = 1'b0;
    repeat (5) tick();
    rst_n = 1'b1;
    tick();
    chk(req_valid_o == 1'b0, "R1", "reset request", req_valid_o, 0);

    // R1: each enable alone low keeps the engine silent.
    sched_en_i = 1'b1; bm_en_i = 1'b1; run_i = 1'b0;
    quiet(15, "R1");
    run_i = 1'b1; bm_en_i = 1'b0;
    quiet(15, "R1");
    bm_en_i = 1'b1; sched_en_i = 1'b0;
    quiet(15, "R1");
    pulse_done();                 // R11: nothing occupied, must be ignored
    sched_en_i = 1'b1;

    // R3/R10: first queue head at the list address, stalled three cycles.
    expect_req(0, 32'h1000, 17, "R3", 3);
    rsp_qh(1'b0, 32'h1100, 32'h2000);
    expect_req(1, 32'h2000, 13, "R8", 0);
    rsp_td(1'b1, 32'h3014, 40);
    data_seq(32'h3014, 40, 0, "R9");

    // R6/R5: second transaction prefetched, its payload flows with both slots full.
    do_fetch(32'h1100, 32'h1200, 32'h2100, 1'b1, 32'h4000, 20, "R6");
    quiet(20, "R5/R11");

    // R4: refill latency after a completion pulse.
    pulse_done();
    n = 1;
    while (!req_valid_o && n < 20) begin
      tick();
      n++;
    end
    chk(n == 2, "R4", "refill edges", n, 2);
    do_fetch(32'h1200, 32'h1300, 32'h2200, 1'b0, 32'h0, 0, "R3");
    quiet(12, "R9");              // no payload, slots full again

    pulse_done(); pulse_done(); pulse_done();
    do_fetch(32'h1300, 32'h1400, 32'h2300, 1'b1, 32'h5000, 0, "R3");
    do_fetch(32'h1400, 32'h1500, 32'h2400, 1'b1, 32'h5100, 3, "R6");
    quiet(12, "R5");

    // R7: prefetch disabled serialises transactions.
    prefetch_en_i = 1'b0;
    pulse_done(); pulse_done();
    do_fetch(32'h1500, 32'h1600, 32'h2500, 1'b0, 32'h0, 0, "R7");
    quiet(20, "R7");
    pulse_done();

    // R9 sweep: every chunk select, three offsets, five lengths.
    q = 32'h1600;
    for (int sel = 0; sel < 4; sel++) begin
      for (int o = 0; o < 3; o++) begin
        for (int li = 0; li < 5; li++) begin
          int win = 16 << sel;
          int off = (o == 0) ? 0 : ((o == 1) ? 1 : win - 1);
          int lens[5] = '{1, win, win + 1, 129, 200};
          logic [31:0] dp = 32'h0010_0000 + 32'(off * 4);
          max_len_sel_i = 2'(sel);
          do_fetch(q, q + 32'h40, 32'h7000, 1'b1, dp, lens[li], "R3");
          q = q + 32'h40;
          pulse_done();
        end
      end
    end

    // R2: sleep on a head-flagged queue head, wake re-reads it.
    expect_req(0, q, 17, "R3", 0);
    rsp_qh(1'b1, q + 32'h40, 32'h7100);
    quiet(20, "R2");
    wake_i = 1'b1; tick(); wake_i = 1'b0;
    expect_req(0, q, 17, "R2", 0);
    recl_i = 1'b1;
    rsp_qh(1'b1, q + 32'h40, 32'h7100);
    expect_req(1, 32'h7100, 13, "R2", 0);
    rsp_td(1'b0, 32'h0, 0);
    recl_i = 1'b0;
    pulse_done();
    expect_req(0, q + 32'h40, 17, "R3", 0);
    rsp_qh(1'b1, q + 32'h80, 32'h7200);
    quiet(10, "R2");

    // R2/R3: schedule off clears sleep, restart reads the new list address.
    sched_en_i = 1'b0; list_addr_i = 32'h0000_9000;
    repeat (3) tick();
    sched_en_i = 1'b1;
    do_fetch(32'h9000, 32'h9100, 32'h7300, 1'b0, 32'h0, 0, "R3");
    quiet(10, "R7");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule